// File: doc/BRIEF.md
# Interval Interrupt Timer with Control and Status Register

This block produces a periodic or one-shot interrupt for a real-time clock. It counts a 10 Hz setting-pulse enable that arrives as a single-cycle strobe. A 4-bit interrupt register picks one of seven periods, from a tenth of a second up to a minute, and chooses single-shot or repeated operation. A control register at address 0 has two faces. On write it holds four control latches: test mode, clock halt, interrupt-register select and interrupt stop. On read it returns two status flags: the data-changed flag and the interrupt flag.

The interrupt pin is open-drain and active low, so it appears here as an output-enable, `irq_oe`. When `irq_oe` is 1 the pin is pulled low. Reading address 0 clears both flags and the pin. The clear takes effect when the read strobe ends, and the flags stay frozen while that read is in progress. A timeout that lands during the read is held back and shows once the read finishes. The block also decodes address F. The select bit decides whether address F reaches the interrupt register inside this block or the clock-setting register, which lives elsewhere. In test mode with no period programmed, the oscillator tick is passed straight to the interrupt pin.

Top module: `irqt_timer`

## Requirements
- R1: After reset the control latches read test=0, halt=0, select=0 and interrupt-stop=1, the period code is 000 and both flags are 0. A write to address 0 loads wdata[3]=test mode, wdata[2]=clock halt, wdata[1]=interrupt-register select and wdata[0]=interrupt stop. A read of address 0 returns {data-changed, 0, 0, interrupt flag}.
- R2: Interrupt-register bits [2:0] choose a period measured in 10 Hz pulses: 001=1, 010=5, 011=10, 100=50, 101=100, 110=300, 111=600. The first timeout comes on the N-th pulse after the timer starts.
- R3: Writing period code 000 clears the interrupt flag and any deferred timeout and forces interrupt-stop to 1. While the code is 000, writing 0 to the stop bit does not start the timer.
- R4: In single mode (interrupt-register bit 3 = 0), the timer sets interrupt-stop after one timeout. Writing 0 to the stop bit starts a new full period.
- R5: Writing 1 to the stop bit halts the timer and resets its count. The next start waits a full period before the next timeout.
- R6: In repeated mode (bit 3 = 1), timeouts recur every N pulses after the first one, with no drift and no software action.
- R7: A timeout sets the interrupt flag and asserts `irq_oe`. Only the end of a control-register read, or a write of code 000, clears them. Reads of other addresses and writes to any address leave them unchanged.
- R8: While a control read is active, the flags and the read data hold still. A timeout during that read asserts `irq_oe` only after the read ends. A pulse during that read does not set the data-changed flag.
- R9: Every 10 Hz pulse outside a control read sets the data-changed flag.
- R10: When select=1, address F reads back {mode, code} and is written as the interrupt register. When select=0, `setting_sel` goes high while the address is F, and this block ignores that access.
- R11: With test mode on and code 000, `irq_oe` follows `osc_tick`. Once a period is programmed, `irq_oe` follows the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_10hz | input | 1 | One-cycle setting-pulse enable at 10 Hz |
| osc_tick | input | 1 | Oscillator tick level used in test mode |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, held for the length of the read |
| bus_rdata | output | 4 | Read data for address 0 and for the interrupt register |
| setting_sel | output | 1 | Address F is routed to the external clock-setting register |
| clk_halt | output | 1 | Clock-halt latch |
| test_mode | output | 1 | Test-mode latch |
| irq_oe | output | 1 | Pull-down enable for the open-drain interrupt pin |

## Verification
Five properties are checked on every clock:
- code 000 always implies the stop bit is set;
- a single-mode timeout always leads to a halt;
- a stopped timer holds a count of zero;
- the flags never move during a control read;
- the interrupt flag falls only after a control read ends or after code 000 is written.

The bench's scenarios are needed for everything else. They measure the exact pulse counts for all seven periods and the absence of drift over several repeated periods. They show the deferred timeout appearing once a long read is released, and confirm that reads of other addresses leave the pin asserted. They also cover the test-mode passthrough of the oscillator tick.

// File: rtl/irqt_pkg.sv
// Package: shared constants and the period lookup for the interval timer.
// Assumes the tick enable runs at TICKS_PER_SEC pulses per second.
package irqt_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 4;
    localparam int CODE_W   = 3;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_IREG = 4'hF;

    // Number of tick pulses in the period selected by a code (0 = none).
    function automatic int period_ticks(input logic [CODE_W-1:0] code, input int tps);
        case (code)
            3'd1: period_ticks = tps / 10;
            3'd2: period_ticks = tps / 2;
            3'd3: period_ticks = tps;
            3'd4: period_ticks = 5 * tps;
            3'd5: period_ticks = 10 * tps;
            3'd6: period_ticks = 30 * tps;
            3'd7: period_ticks = 60 * tps;
            default: period_ticks = 0;
        endcase
    endfunction
endpackage

// File: rtl/irqt_ctrl.sv
// Control latches and interrupt register.
// Holds test, clock halt, register select, interrupt stop, period code and mode.
// Code 000 forces the stop bit; a single-mode timeout also sets it.
// Assumes a write and a read never happen in the same cycle.
module irqt_ctrl
    import irqt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_ireg,
    input  logic [DATA_W-1:0] wdata,
    input  logic              timeout,
    output logic              test_q,
    output logic              halt_q,
    output logic              sel_q,
    output logic              stop_q,
    output logic [CODE_W-1:0] code_q,
    output logic              rep_q,
    output logic              clr_all
);
    logic code_zero;
    logic wr_zero_code;

    assign code_zero    = (code_q == '0);
    assign wr_zero_code = wr_ireg && (wdata[CODE_W-1:0] == '0);
    assign clr_all      = wr_zero_code;

    // Control-register write latches (everything except the stop bit).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q <= 1'b0;
            halt_q <= 1'b0;
            sel_q  <= 1'b0;
        end else if (wr_ctrl) begin
            test_q <= wdata[3];
            halt_q <= wdata[2];
            sel_q  <= wdata[1];
        end
    end

    // Interrupt register: period code and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            rep_q  <= 1'b0;
        end else if (wr_ireg) begin
            code_q <= wdata[CODE_W-1:0];
            rep_q  <= wdata[3];
        end
    end

    // Interrupt stop bit. Writes win over a timeout; code 000 pins it to 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b1;
        end else if (wr_ctrl) begin
            stop_q <= wdata[0] | code_zero;
        end else if (wr_zero_code) begin
            stop_q <= 1'b1;
        end else if (timeout && !rep_q) begin
            stop_q <= 1'b1;
        end
    end
endmodule

// File: rtl/irqt_period.sv
// Period counter: counts tick pulses while running and fires on the last one.
// Restarts from zero right after a timeout, so repeated periods stay exact.
// Assumes the limit is at least 1 whenever run is high.
module irqt_period #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             timeout,
    output logic [CNT_W-1:0] cnt_q
);
    logic last;

    assign last    = (cnt_q >= limit - CNT_W'(1));
    assign timeout = run && tick && last;

    // Tick counter, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/irqt_flags.sv
// Status flags: data-changed and interrupt flags plus the deferred timeout.
// Flags freeze during a control read and clear when it ends.
// Events that arrive during the read are stored and applied at the end.
module irqt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_act,
    input  logic tick,
    input  logic timeout,
    input  logic clr_all,
    output logic dcf_q,
    output logic iflag_q
);
    logic act_q;
    logic pend_q;
    logic trail;

    assign trail = act_q && !ctrl_act;

    // Remembers whether a control read was active in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= ctrl_act;
    end

    // Data-changed flag: frozen during a read, cleared at its end.
    always_ff @(posedge clk) begin
        if (!rst_n)        dcf_q <= 1'b0;
        else if (ctrl_act) dcf_q <= dcf_q;
        else if (trail)    dcf_q <= tick;
        else if (tick)     dcf_q <= 1'b1;
    end

    // Interrupt flag and the timeout held back during a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iflag_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (clr_all) begin
            iflag_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (ctrl_act) begin
            if (timeout) pend_q <= 1'b1;
        end else if (trail) begin
            iflag_q <= pend_q | timeout;
            pend_q  <= 1'b0;
        end else if (timeout) begin
            iflag_q <= 1'b1;
        end
    end
endmodule

// File: rtl/irqt_timer.sv
// Top: address decode, read mux, interrupt pin mux and glue between submodules.
// The bus read strobe is a level held for the whole read. Writes last one cycle.
// irq_oe = 1 means the open-drain pin is pulled low.
module irqt_timer
    import irqt_pkg::*;
#(
    parameter int TICKS_PER_SEC = 10,
    parameter int CNT_W         = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_10hz,
    input  logic              osc_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              setting_sel,
    output logic              clk_halt,
    output logic              test_mode,
    output logic              irq_oe
);
    logic              hit_ctrl, hit_f;
    logic              wr_ctrl, wr_ireg, ctrl_act;
    logic              test_q, halt_q, sel_q, stop_q, rep_q, clr_all;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  limit, cnt_q;
    logic              timeout, dcf_q, iflag_q;

    assign hit_ctrl = (bus_addr == ADDR_CTRL);
    assign hit_f    = (bus_addr == ADDR_IREG);
    assign wr_ctrl  = bus_wr && hit_ctrl;
    assign wr_ireg  = bus_wr && hit_f && sel_q;
    assign ctrl_act = bus_rd && hit_ctrl;
    assign limit    = CNT_W'(period_ticks(code_q, TICKS_PER_SEC));

    irqt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_ireg (wr_ireg),
        .wdata   (bus_wdata),
        .timeout (timeout),
        .test_q  (test_q),
        .halt_q  (halt_q),
        .sel_q   (sel_q),
        .stop_q  (stop_q),
        .code_q  (code_q),
        .rep_q   (rep_q),
        .clr_all (clr_all)
    );

    irqt_period #(.CNT_W(CNT_W)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!stop_q),
        .tick    (tick_10hz),
        .limit   (limit),
        .timeout (timeout),
        .cnt_q   (cnt_q)
    );

    irqt_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_act (ctrl_act),
        .tick     (tick_10hz),
        .timeout  (timeout),
        .clr_all  (clr_all),
        .dcf_q    (dcf_q),
        .iflag_q  (iflag_q)
    );

    // Read data mux: status at address 0, interrupt register at F when selected.
    always_comb begin
        bus_rdata = '0;
        if (ctrl_act)
            bus_rdata = {dcf_q, 2'b00, iflag_q};
        else if (bus_rd && hit_f && sel_q)
            bus_rdata = {rep_q, code_q};
    end

    // Interrupt pin: oscillator passthrough in test mode with no period set.
    always_comb begin
        if (test_q && (code_q == '0)) irq_oe = osc_tick;
        else                          irq_oe = iflag_q;
    end

    assign setting_sel = hit_f && !sel_q;
    assign clk_halt    = halt_q;
    assign test_mode   = test_q;
endmodule

// File: rtl/irqt_checker.sv
// Checker for irqt_timer, attached by bind. It watches internal state across submodules.
module irqt_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_q,
    input logic [2:0]       code_q,
    input logic             rep_q,
    input logic             timeout,
    input logic             wr_ctrl,
    input logic             bus_wr,
    input logic             ctrl_act,
    input logic             clr_all,
    input logic             dcf_q,
    input logic             iflag_q,
    input logic [CNT_W-1:0] cnt_q
);
    a_r3_code0_forces_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == 3'd0) |-> stop_q);

    a_r4_single_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !rep_q && !wr_ctrl) |=> stop_q);

    a_r5_stopped_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> (cnt_q == '0));

    a_r8_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_act && $past(ctrl_act) && !bus_wr && !$past(bus_wr)) |-> ($stable(dcf_q) && $stable(iflag_q)));

    a_r7_clear_by_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iflag_q) |-> (($past(ctrl_act, 2) && !$past(ctrl_act)) || $past(clr_all)));
endmodule

bind irqt_timer irqt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_q   (stop_q),
    .code_q   (code_q),
    .rep_q    (rep_q),
    .timeout  (timeout),
    .wr_ctrl  (wr_ctrl),
    .bus_wr   (bus_wr),
    .ctrl_act (ctrl_act),
    .clr_all  (clr_all),
    .dcf_q    (dcf_q),
    .iflag_q  (iflag_q),
    .cnt_q    (cnt_q)
);

// File: tb/irqt_timer_test.sv
// Bench: behavioural per-cycle reference model compared on every clock, plus directed checks.
module irqt_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_10hz = 1'b0, osc_tick = 1'b0;
    logic [3:0] bus_addr = 4'h0, bus_wdata = 4'h0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_rdata;
    logic       setting_sel, clk_halt, test_mode, irq_oe;

    always #2.5 clk = ~clk;

    irqt_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_10hz(tick_10hz), .osc_tick(osc_tick),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .setting_sel(setting_sel), .clk_halt(clk_halt),
        .test_mode(test_mode), .irq_oe(irq_oe)
    );

    int    n_run = 0, n_fail = 0, gcyc = 0;
    bit    tick_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    bit m_test, m_halt, m_sel, m_stop, m_rep, m_dcf, m_iflag, m_pend, m_act;
    int m_code, m_cnt;

    function automatic int lim(int c);
        int t[8] = '{0, 1, 5, 10, 50, 100, 300, 600};
        return t[c];
    endfunction

    task automatic check(string req, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", req, got, exp, gcyc);
        end
    endtask

    // One model step using the state before the edge and the applied inputs.
    task automatic model_step();
        bit act, trail, to, wctrl, wireg;
        if (!rst_n) begin
            m_test = 0; m_halt = 0; m_sel = 0; m_stop = 1; m_rep = 0; m_code = 0;
            m_cnt = 0; m_dcf = 0; m_iflag = 0; m_pend = 0; m_act = 0;
            return;
        end
        act   = bus_rd && bus_addr == 4'h0;
        trail = m_act && !act;
        to    = !m_stop && tick_10hz && (m_cnt + 1 >= lim(m_code));
        wctrl = bus_wr && bus_addr == 4'h0;
        wireg = bus_wr && bus_addr == 4'hF && m_sel;
        // flags
        if (wireg && bus_wdata[2:0] == 0) begin m_iflag = 0; m_pend = 0; end
        else if (act) begin if (to) m_pend = 1; end
        else if (trail) begin m_iflag = m_pend | to; m_pend = 0; end
        else if (to) m_iflag = 1;
        if (!act) begin
            if (trail) m_dcf = tick_10hz;
            else if (tick_10hz) m_dcf = 1;
        end
        // counter
        if (m_stop) m_cnt = 0;
        else if (tick_10hz) m_cnt = to ? 0 : m_cnt + 1;
        // control
        if (wctrl) begin
            m_test = bus_wdata[3]; m_halt = bus_wdata[2]; m_sel = bus_wdata[1];
            m_stop = bus_wdata[0] | (m_code == 0);
        end else if (wireg && bus_wdata[2:0] == 0) m_stop = 1;
        else if (to && !m_rep) m_stop = 1;
        if (wireg) begin m_code = int'(bus_wdata[2:0]); m_rep = bus_wdata[3]; end
        m_act = act;
    endtask

    // One clock: drive ticks, step the model at the edge, compare at the falling edge.
    task automatic cyc();
        int exp_rd, exp_irq;
        tick_10hz = tick_on && (gcyc % 4 == 3);
        osc_tick  = gcyc[0];
        @(posedge clk);
        model_step();
        @(negedge clk);
        exp_rd = 0;
        if (bus_rd && bus_addr == 4'h0) exp_rd = {m_dcf, 2'b00, m_iflag};
        else if (bus_rd && bus_addr == 4'hF && m_sel) exp_rd = {m_rep, m_code[2:0]};
        exp_irq = (m_test && m_code == 0) ? int'(osc_tick) : int'(m_iflag);
        if (rst_n) begin
            check(cur_req, irq_oe, exp_irq);
            check(cur_req, bus_rdata, exp_rd);
            check(cur_req, {setting_sel, clk_halt, test_mode},
                  {bus_addr == 4'hF && !m_sel, m_halt, m_test});
        end
        gcyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(logic [3:0] a, logic [3:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1; cyc(); bus_wr = 0;
    endtask

    // Hold a read for n cycles; returns the data seen in the first and last cycle.
    task automatic rd(logic [3:0] a, int n, output logic [3:0] first, output logic [3:0] last);
        bus_addr = a; bus_rd = 1;
        for (int i = 0; i < n; i++) begin
            cyc();
            if (i == 0) first = bus_rdata;
            last = bus_rdata;
        end
        bus_rd = 0; bus_addr = 4'h1;
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] f, l;
        int n;
        @(negedge clk);
        idle(3);
        rst_n = 1; bus_addr = 4'h1;
        // R1: reset state
        cur_req = "R1";
        cyc();
        check("R1", {clk_halt, test_mode, irq_oe}, 3'b000);
        rd(4'h0, 1, f, l);
        check("R1", f, 4'h0);
        // R1 and R11: control write fields, oscillator passthrough
        wr(4'h0, 4'b1111);
        check("R1", {test_mode, clk_halt}, 2'b11);
        cur_req = "R11";
        n = 0;
        for (int i = 0; i < 6; i++) begin cyc(); if (irq_oe == osc_tick) n++; end
        check("R11", n, 6);
        // R10: interrupt register readback
        cur_req = "R10";
        wr(4'hF, 4'b0010);
        rd(4'hF, 1, f, l);
        check("R10", f, 4'b0010);
        wr(4'h0, 4'b0011);
        check("R11", test_mode, 0);
        tick_on = 1;
        // R9: data-changed flag on pulses
        cur_req = "R9";
        rd(4'h0, 1, f, l); idle(9);
        rd(4'h0, 1, f, l);
        check("R9", f[3], 1);
        // R2: all seven periods, counted in pulses
        cur_req = "R2";
        for (int c = 1; c < 8; c++) begin
            wr(4'h0, 4'b0011);
            wr(4'hF, 4'(c));
            rd(4'h0, 1, f, l); idle(1);
            wr(4'h0, 4'b0010);
            n = 0;
            for (int i = 0; i < 3000; i++) begin
                cyc();
                if (tick_10hz) n++;
                if (irq_oe) break;
            end
            check("R2", n, lim(c));
        end
        // R4: single mode stays quiet after its timeout until restarted
        cur_req = "R4";
        rd(4'h0, 1, f, l); idle(1);
        wr(4'h0, 4'b0011); wr(4'hF, 4'b0010); wr(4'h0, 4'b0010);
        idle(30); rd(4'h0, 1, f, l); idle(40);
        check("R4", irq_oe, 0);
        wr(4'h0, 4'b0010); idle(24);
        check("R4", irq_oe, 1);
        // R7: other accesses leave the interrupt asserted; control read clears it
        cur_req = "R7";
        rd(4'h5, 3, f, l); wr(4'h3, 4'h9); idle(2);
        check("R7", irq_oe, 1);
        rd(4'h0, 1, f, l);
        check("R7", f[0], 1);
        idle(1);
        check("R7", irq_oe, 0);
        // R5: stop resets the count, restart gives a full period
        cur_req = "R5";
        wr(4'h0, 4'b0010); idle(12); wr(4'h0, 4'b0011); idle(3);
        wr(4'h0, 4'b0010);
        n = 0;
        for (int i = 0; i < 200; i++) begin cyc(); if (tick_10hz) n++; if (irq_oe) break; end
        check("R5", n, 5);
        // R6: repeated mode at 10 pulses, five periods without drift
        cur_req = "R6";
        rd(4'h0, 1, f, l); idle(1);
        wr(4'h0, 4'b0011); wr(4'hF, 4'b1011); wr(4'h0, 4'b0010);
        for (int p = 0; p < 5; p++) begin
            n = 0;
            for (int i = 0; i < 200; i++) begin cyc(); if (tick_10hz) n++; if (irq_oe) break; end
            check("R6", n, 10);
            rd(4'h0, 1, f, l);
        end
        // R8: long read with timeouts inside it
        cur_req = "R8";
        wr(4'h0, 4'b0011); wr(4'hF, 4'b1001); rd(4'h0, 1, f, l); idle(1);
        wr(4'h0, 4'b0010);
        rd(4'h0, 20, f, l);
        check("R8", l, f);
        check("R8", irq_oe, f[0]);
        cyc();
        check("R8", irq_oe, 1);
        // R3: code 000 clears the pin and blocks starting
        cur_req = "R3";
        wr(4'hF, 4'b1000);
        check("R3", irq_oe, 0);
        wr(4'h0, 4'b0010); idle(40);
        check("R3", irq_oe, 0);
        // R10: address F routed to clock setting register when select is 0
        cur_req = "R10";
        wr(4'h0, 4'b0000);
        bus_addr = 4'hF; cyc();
        check("R10", setting_sel, 1);
        rd(4'hF, 1, f, l);
        check("R10", f, 4'h0);
        idle(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule